// File: doc/BRIEF.md
# Sectored Effective Address Generator

This block forms the final word address of a memory-reference instruction for a 16-bit, word-addressed minicomputer with a 16K-word address space split into 512-word sectors. The caller presents an instruction word, the address that instruction was fetched from, the index register and the base-sector register, then pulses `start`. The 9-bit in-sector offset of the instruction is placed either in the base sector or in the instruction's own sector. It is then optionally offset by the index register. If the instruction asks for indirection, the block reads pointer words through a one-outstanding memory read port. Each pointer word may add the index register again and may ask for yet another pointer read. The chain has no length limit.

When the address is final the block shows it on `ea` together with a one-cycle `done` pulse. A synchronous `abort` drops any chain in progress and returns the block to idle. The surrounding control logic uses it to escape a pointer loop that never ends. Opcode execution, operand access, the memory array and interrupts are outside this block.

Top module: `ea_chain_gen`

## Requirements
- R1: Instruction word fields: bit 15 is the indirect flag, bit 14 the index flag, bit 9 the sector-select bit, bits 8:0 the in-sector offset; bits 13:10 (opcode) do not affect the result. With bit 9 clear the address is `{base_sector, offset}`; the base sector may be any of the 32 sectors.
- R2: With bit 9 set the address is `{instr_addr[13:9], offset}`, i.e. the sector holding the instruction.
- R3: When an index flag is set, the low 14 bits of `index_val` are added to the address formed so far, modulo 16384; bits 15:14 of `index_val` have no effect.
- R4: When both flags are set in the instruction, indexing is applied first, so the first pointer read uses the indexed address.
- R5: A pointer word holds the next indirect flag in bit 15, the next index flag in bit 14 and a full 14-bit address in bits 13:0; pointer reads repeat while the indirect flag is set, with no limit on depth.
- R6: `rd_req` stays high with `rd_addr` unchanged until the cycle in which `rd_valid` is seen; each accepted read advances the chain by exactly one level.
- R7: `done` is a single-cycle pulse and `ea` is valid in that cycle; with no indirection `done` rises one clock after `start` is sampled, otherwise one clock after the last `rd_valid`.
- R8: `abort` sampled high returns the block to idle on the next clock with `busy`, `rd_req` and `done` low, and it overrides a simultaneous `start` or `rd_valid`.
- R9: `start` is ignored while `busy` is high; the running chain completes with its own result.
- R10: During and after reset `done`, `rd_req` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin address formation for `instr` (accepted when idle) |
| instr | input | 16 | Instruction word |
| instr_addr | input | 14 | Address of the instruction itself |
| index_val | input | 16 | Index register contents |
| base_sector | input | 5 | Sector number used when the sector bit is clear |
| abort | input | 1 | Synchronous return to idle |
| rd_req | output | 1 | Pointer read request, held until accepted |
| rd_addr | output | 14 | Pointer read address |
| rd_valid | input | 1 | Read data valid, accepts the pending request |
| rd_data | input | 16 | Pointer word returned by memory |
| ea | output | 14 | Final effective address, valid with `done` |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | A pointer chain is in progress |

## Verification
Direct patterns are tried with the sector bit in both states and with a nonzero base sector, which tells base-sector placement apart from current-sector placement. Indexed patterns include one whose sum crosses the top of memory and one with the high index bits set, which separates modulo-16K wrapping and index truncation from plain addition. Indirect patterns use a memory map where reading the unindexed address would return a different pointer, so index-before-indirect ordering is distinguishable. Other patterns chain two pointers with index flags at different levels, under memory latencies of zero to two cycles. Directed cases cover reset, a start during a chain, the request hold under slow memory, and abort out of a self-referencing pointer loop.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    // Control state of the generator.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ea_state_e;

endpackage

// File: rtl/ea_sector_sel.sv
// Places an in-sector offset into either the base sector or the
// sector that holds the instruction.
module ea_sector_sel #(
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 9,
    localparam int SEC_W = ADDR_W - OFF_W
) (
    input  logic              use_cur,
    input  logic [OFF_W-1:0]  offset,
    input  logic [ADDR_W-1:0] here_addr,
    input  logic [SEC_W-1:0]  base_sec,
    output logic [ADDR_W-1:0] addr
);
    logic [SEC_W-1:0] sec_pick;
    logic [OFF_W-1:0] here_unused;

    assign here_unused = here_addr[OFF_W-1:0];

    always_comb begin
        sec_pick = use_cur ? here_addr[ADDR_W-1:OFF_W] : base_sec;
        addr     = {sec_pick, offset};
    end
endmodule

// File: rtl/ea_index_add.sv
// Conditional index addition, wrapping modulo 2**ADDR_W.
module ea_index_add #(
    parameter int ADDR_W = 14
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] xval,
    output logic [ADDR_W-1:0] addr_out
);
    always_comb begin
        addr_out = en ? (addr_in + xval) : addr_in;
    end
endmodule

// File: rtl/ea_ptr_decode.sv
// Splits a word into its indirect flag, index flag and address field.
module ea_ptr_decode #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 14
) (
    input  logic [WORD_W-1:0] word,
    output logic              ind,
    output logic              idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int IND_POS = WORD_W - 1;
    localparam int IDX_POS = WORD_W - 2;

    assign ind  = word[IND_POS];
    assign idx  = word[IDX_POS];
    assign addr = word[ADDR_W-1:0];

    generate
        if (IDX_POS > ADDR_W) begin : g_spare
            logic [IDX_POS-ADDR_W-1:0] spare_unused;
            assign spare_unused = word[IDX_POS-1:ADDR_W];
        end
    endgenerate
endmodule

// File: rtl/ea_chain_gen.sv
module ea_chain_gen
    import ea_gen_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 9,
    localparam int SEC_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] instr,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [WORD_W-1:0] index_val,
    input  logic [SEC_W-1:0]  base_sector,
    input  logic              abort,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ea,
    output logic              done,
    output logic              busy
);
    localparam int F_POS = WORD_W - 1;
    localparam int T_POS = WORD_W - 2;
    localparam int S_POS = OFF_W;

    typedef struct packed {
        ea_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              req;
        logic              done;
    } gen_t;

    gen_t r_q, r_d;

    // Bits that never take part in address formation.
    logic [T_POS-S_POS-2:0]   opc_unused;
    logic [WORD_W-ADDR_W-1:0] xhi_unused;
    assign opc_unused = instr[T_POS-1:S_POS+1];
    assign xhi_unused = index_val[WORD_W-1:ADDR_W];

    // Instruction path: sector selection, then optional index.
    logic [ADDR_W-1:0] ins_sec_addr, ins_ea;

    ea_sector_sel #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_sec (
        .use_cur   (instr[S_POS]),
        .offset    (instr[OFF_W-1:0]),
        .here_addr (instr_addr),
        .base_sec  (base_sector),
        .addr      (ins_sec_addr)
    );

    ea_index_add #(.ADDR_W(ADDR_W)) u_ins_idx (
        .en       (instr[T_POS]),
        .addr_in  (ins_sec_addr),
        .xval     (index_val[ADDR_W-1:0]),
        .addr_out (ins_ea)
    );

    // Pointer path: decode returned word, then optional index.
    logic              ptr_ind, ptr_idx;
    logic [ADDR_W-1:0] ptr_raw, ptr_ea;

    ea_ptr_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
        .word (rd_data),
        .ind  (ptr_ind),
        .idx  (ptr_idx),
        .addr (ptr_raw)
    );

    ea_index_add #(.ADDR_W(ADDR_W)) u_ptr_idx (
        .en       (ptr_idx),
        .addr_in  (ptr_raw),
        .xval     (index_val[ADDR_W-1:0]),
        .addr_out (ptr_ea)
    );

    // Next-state logic.
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr = ins_ea;
                    if (instr[F_POS]) begin
                        r_d.st  = ST_FETCH;
                        r_d.req = 1'b1;
                    end else begin
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (rd_valid) begin
                    r_d.addr = ptr_ea;
                    if (!ptr_ind) begin
                        r_d.st   = ST_IDLE;
                        r_d.req  = 1'b0;
                        r_d.done = 1'b1;
                    end
                end
            end
            default: r_d = r_q;
        endcase
        if (abort) begin
            r_d.st   = ST_IDLE;
            r_d.req  = 1'b0;
            r_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, req: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req  = r_q.req;
    assign rd_addr = r_q.addr;
    assign ea      = r_q.addr;
    assign done    = r_q.done;
    assign busy    = (r_q.st == ST_FETCH);

    // Assertions.
    assert_base_sector_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !abort && !instr[F_POS] && !instr[T_POS] && !instr[S_POS])
        |=> (done && ea[ADDR_W-1:OFF_W] == $past(base_sector)));

    assert_cur_sector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !abort && !instr[F_POS] && !instr[T_POS] && instr[S_POS])
        |=> (done && ea[ADDR_W-1:OFF_W] == $past(instr_addr[ADDR_W-1:OFF_W])));

    assert_plain_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_valid && !abort && !rd_data[F_POS] && !rd_data[T_POS])
        |=> (done && ea == $past(rd_data[ADDR_W-1:0])));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid && !abort) |=> (rd_req && $stable(rd_addr)));

    assert_req_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);

    assert_direct_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !abort && !instr[F_POS]) |=> done);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !rd_req));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !rd_req && !done));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_valid && !abort) |=> (busy && !done && $stable(rd_addr)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R10: assert (!done && !rd_req && !busy);
        end
    end
endmodule

// File: tb/tb_ea_chain_gen.sv
`timescale 1ns/1ps
module tb_ea_chain_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [13:0] instr_addr = '0;
    logic [15:0] index_val = '0;
    logic [4:0]  base_sector = '0;
    logic        abort = 1'b0;
    logic        rd_req;
    logic [13:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = '0;
    logic [13:0] ea;
    logic        done;
    logic        busy;

    always #2 clk = ~clk;   // 250 MHz

    ea_chain_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .instr_addr(instr_addr), .index_val(index_val),
        .base_sector(base_sector), .abort(abort), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .ea(ea), .done(done), .busy(busy)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: a few pointer words, zero elsewhere.
    function automatic logic [15:0] mem_word(input logic [13:0] a);
        case (a)
            14'h0105: return 16'h0234;
            14'h0100: return 16'h0777;
            14'h00F0: return 16'h8300;
            14'h0300: return 16'h4010;
            14'h0050: return 16'hC060;
            14'h0065: return 16'h1ABC;
            14'h0040: return 16'h8040;   // points to itself
            default:  return 16'h0000;
        endcase
    endfunction

    int          rd_lat = 0;
    int          reads  = 0;
    logic [13:0] first_addr = '0;

    initial begin
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (rd_req) begin
                if (reads == 0) first_addr = rd_addr;
                repeat (rd_lat) @(negedge clk);
                rd_data  = mem_word(rd_addr);
                rd_valid = 1'b1;
                reads++;
            end
        end
    end

    // Request-hold monitor (R6).
    logic        pv_req = 1'b0, pv_val = 1'b0;
    logic [13:0] pv_addr = '0;
    int          hold_err = 0;
    always @(negedge clk) begin
        if (rst_n && pv_req && !pv_val && !abort)
            if (!rd_req || rd_addr != pv_addr) hold_err++;
        pv_req  <= rd_req;
        pv_val  <= rd_valid;
        pv_addr <= rd_addr;
    end

    // Vector table.
    localparam int NV = 10;
    localparam logic [15:0] V_INSTR [NV] = '{16'h09A3, 16'h09A3, 16'h0AA3, 16'h4900, 16'h4BFF,
                                             16'hC900, 16'h88F0, 16'h8850, 16'h4900, 16'h3DA3};
    localparam logic [13:0] V_IADDR [NV] = '{14'h0000, 14'h0000, 14'h1234, 14'h0000, 14'h3E00,
                                             14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h0000};
    localparam logic [15:0] V_X     [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0005, 16'h0003,
                                             16'h0005, 16'h0005, 16'h0005, 16'hC005, 16'h0000};
    localparam logic [4:0]  V_BASE  [NV] = '{5'd0, 5'd5, 5'd0, 5'd0, 5'd0,
                                             5'd0, 5'd0, 5'd0, 5'd0, 5'd0};
    localparam logic [13:0] V_EA    [NV] = '{14'h01A3, 14'h0BA3, 14'h12A3, 14'h0105, 14'h0002,
                                             14'h0234, 14'h0015, 14'h1ABC, 14'h0105, 14'h01A3};
    localparam int          V_READS [NV] = '{0, 0, 0, 0, 0, 1, 2, 2, 0, 0};
    localparam string       V_REQ   [NV] = '{"R1", "R1", "R2", "R3", "R3",
                                             "R4", "R5", "R5", "R3", "R1"};

    task automatic launch(input logic [15:0] ins, input logic [13:0] ia,
                          input logic [15:0] x, input logic [4:0] bs);
        @(negedge clk);
        instr = ins; instr_addr = ia; index_val = x; base_sector = bs;
        reads = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        int cyc;
        // Reset state (R10).
        repeat (3) @(negedge clk);
        chk(!done && !rd_req && !busy, "R10", "outputs in reset", {done, rd_req, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rd_req && !busy, "R10", "outputs after reset", {done, rd_req, busy}, 0);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            rd_lat = i % 3;
            launch(V_INSTR[i], V_IADDR[i], V_X[i], V_BASE[i]);
            wait_done(cyc);
            chk(done == 1'b1, V_REQ[i], $sformatf("done seen, vector %0d", i), done, 1);
            chk(ea == V_EA[i], V_REQ[i], $sformatf("ea, vector %0d", i), ea, V_EA[i]);
            chk(reads == V_READS[i], "R5", $sformatf("read count, vector %0d", i), reads, V_READS[i]);
            if (V_READS[i] == 0)
                chk(cyc == 1, "R7", $sformatf("direct latency, vector %0d", i), cyc, 1);
            if (i == 5)
                chk(first_addr == 14'h0105, "R4", "first pointer address indexed", first_addr, 14'h0105);
            @(negedge clk);
            chk(!done, "R7", $sformatf("done single pulse, vector %0d", i), done, 0);
        end

        // Slow memory: request held, one read per level (R6).
        rd_lat = 4;
        launch(16'h88F0, 14'h0, 16'h0005, 5'd0);
        wait_done(cyc);
        chk(ea == 14'h0015, "R6", "ea under slow memory", ea, 14'h0015);
        chk(reads == 2, "R6", "reads under slow memory", reads, 2);
        chk(hold_err == 0, "R6", "request hold violations", hold_err, 0);

        // Start while busy is ignored (R9).
        rd_lat = 3;
        launch(16'h88F0, 14'h0, 16'h0005, 5'd0);
        @(negedge clk);
        chk(busy == 1'b1, "R9", "busy during chain", busy, 1);
        instr = 16'h09A3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done && busy, "R9", "no done from start while busy", {done, busy}, 1);
        wait_done(cyc);
        chk(ea == 14'h0015, "R9", "chain result kept", ea, 14'h0015);
        chk(reads == 2, "R9", "chain read count", reads, 2);
        @(negedge clk);
        chk(!done, "R9", "no second done", done, 0);

        // Abort from an endless pointer loop (R8).
        rd_lat = 0;
        launch(16'h8840, 14'h0, 16'h0, 5'd0);
        repeat (20) @(negedge clk);
        chk(busy && !done, "R8", "still looping before abort", {busy, done}, 2);
        chk(reads > 5, "R5", "unbounded chain keeps reading", reads, 6);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!busy && !rd_req && !done, "R8", "idle after abort", {busy, rd_req, done}, 0);
        repeat (5) @(negedge clk);
        chk(!busy && !done, "R8", "stays idle after abort", {busy, done}, 0);

        // Abort beats a simultaneous start (R8).
        @(negedge clk);
        instr = 16'h09A3; base_sector = 5'd0; start = 1'b1; abort = 1'b1;
        @(negedge clk);
        start = 1'b0; abort = 1'b0;
        chk(!done && !busy, "R8", "abort overrides start", {done, busy}, 0);

        // Normal operation resumes.
        launch(16'hC900, 14'h0, 16'h0005, 5'd0);
        wait_done(cyc);
        chk(ea == 14'h0234, "R4", "result after abort", ea, 14'h0234);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule